// File: doc/BRIEF.md
# Staged-Update Multi-Channel PWM Generator

This block produces several independent pulse-width-modulated outputs. Software programs them through a small register interface with write and read strobes. A shared control word holds, for each channel, a trigger bit, a smooth bit and a polarity bit. A shared prescale word holds one prescale field per channel. Each channel also has its own period register and duty register.

Software writes into holding registers only. A channel's running waveform changes only when a commit handshake completes. First, software raises the smooth bit and drops the trigger bit, and the channel keeps its old waveform. Later, software raises the trigger bit with smooth clear and holds it for a minimum number of clock cycles. A trigger that rises too soon after it fell, or that falls too early, is discarded. A completed commit moves the staged period, duty, prescale and polarity into the channel together. They take effect at the channel's next period boundary, or at once if the channel is idle. The output therefore never shows a partly updated waveform.

A channel whose committed period is zero is idle, and its output rests at the inactive level set by its polarity.

Top module: `pwm_staged_top`

## Requirements
- R1: Register addresses are: 0 control, 1 prescale, 2+2*c period of channel c, 3+2*c duty of channel c. A read (rd_en) returns the stored value on rdata in the following cycle, and unmapped addresses read as zero.
- R2: Writes to the period, duty, prescale or control registers do not change a channel's output until that channel completes a commit.
- R3: The control bits of channel c are: trigger at bit 3*c, smooth at bit 3*c+1, polarity at bit 3*c+2. A trigger that rises and then stays high for HOLD_CYC cycles with smooth clear commits period, duty, prescale and polarity. These take effect at the next period boundary, or at once if the channel is idle.
- R4: A trigger pulse that falls before HOLD_CYC cycles have passed commits nothing.
- R5: A trigger that rises fewer than HOLD_CYC cycles after it last fell is ignored, even if it is then held long. After reset, the trigger counts as having been low long enough.
- R6: If smooth is still set when the trigger hold time completes, nothing is committed.
- R7: The waveform advances once every (prescale+1) clocks. A period lasts period*(prescale+1) clocks. The output is active for min(duty,period)*(prescale+1) clocks of each period.
- R8: The prescale field of channel c is bits [c*PSW +: PSW] of the prescale register. A commit on one channel leaves the waveforms of all other channels unchanged.
- R9: A channel committed with period zero is idle, and its output stays constantly at the inactive level.
- R10: Polarity 0 drives an active-high output. Polarity 1 inverts the output, so an idle channel rests high.
- R11: After reset all registers read zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid the cycle after rd_en |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
On every cycle, assertions check three things. A commit pulse occurs only while the trigger has been high for two samples with smooth clear. The committed values of a channel change only in an apply cycle. An idle channel drives exactly its polarity level. Other behaviour can only be seen over time, by counting active cycles over whole periods. This covers the rejection of short pulses and early re-triggers, and the protection of old waveforms during staging. It also covers the independence of the channels and the duty arithmetic across prescale values, and the bench's scenarios show these.

// File: rtl/pwm_stage_pkg.sv
package pwm_stage_pkg;
  localparam int CTRL_ADDR   = 0;
  localparam int PRESC_ADDR  = 1;
  localparam int CH_BASE     = 2;
  localparam int CTRL_STRIDE = 3;
  localparam int TRIG_OFS    = 0;
  localparam int SMOOTH_OFS  = 1;
  localparam int POL_OFS     = 2;
endpackage

// File: rtl/pwm_stage_regs.sv
module pwm_stage_regs
  import pwm_stage_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 4,
  parameter int CW  = 16,
  parameter int PSW = 4,
  localparam int CTW = CTRL_STRIDE * NCH,
  localparam int PRW = PSW * NCH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic [CTW-1:0]         ctrl_o,
  output logic [PRW-1:0]         presc_o,
  output logic [NCH-1:0][CW-1:0] per_o,
  output logic [NCH-1:0][CW-1:0] duty_o
);
  logic [DW-1:0]          ctrl_q, ctrl_d, presc_q, presc_d, rdata_q, rdata_d;
  logic [NCH-1:0][CW-1:0] per_q, per_d, duty_q, duty_d;

  always_comb begin
    ctrl_d  = ctrl_q;
    presc_d = presc_q;
    per_d   = per_q;
    duty_d  = duty_q;
    if (wr_en) begin
      if (addr == AW'(CTRL_ADDR))  ctrl_d  = wdata;
      if (addr == AW'(PRESC_ADDR)) presc_d = wdata;
      for (int c = 0; c < NCH; c++) begin
        if (addr == AW'(CH_BASE + 2*c))     per_d[c]  = wdata[CW-1:0];
        if (addr == AW'(CH_BASE + 2*c + 1)) duty_d[c] = wdata[CW-1:0];
      end
    end
  end

  always_comb begin
    rdata_d = '0;
    if (addr == AW'(CTRL_ADDR))  rdata_d = ctrl_q;
    if (addr == AW'(PRESC_ADDR)) rdata_d = presc_q;
    for (int c = 0; c < NCH; c++) begin
      if (addr == AW'(CH_BASE + 2*c))     rdata_d = DW'(per_q[c]);
      if (addr == AW'(CH_BASE + 2*c + 1)) rdata_d = DW'(duty_q[c]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      per_q   <= '0;
      duty_q  <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      presc_q <= presc_d;
      per_q   <= per_d;
      duty_q  <= duty_d;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign rdata   = rdata_q;
  assign ctrl_o  = ctrl_q[CTW-1:0];
  assign presc_o = presc_q[PRW-1:0];
  assign per_o   = per_q;
  assign duty_o  = duty_q;

  // R1: a read strobe delivers the addressed word one cycle later
  p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(CTRL_ADDR)) |=> rdata == $past(ctrl_q));
endmodule

// File: rtl/pwm_stage_gate.sv
module pwm_stage_gate #(
  parameter int HOLD_CYC = 40,
  localparam int CNTW = $clog2(HOLD_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic smooth,
  output logic commit
);
  localparam logic [CNTW-1:0] LAST = CNTW'(HOLD_CYC - 1);

  logic            trig_q, armed_q, armed_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            rise, fall;

  assign rise = trig & ~trig_q;
  assign fall = ~trig & trig_q;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    commit  = 1'b0;
    if (rise) begin
      armed_d = (cnt_q == LAST);   // low long enough since the last fall
      cnt_d   = '0;
    end else if (fall) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else begin
      if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
      if (trig && armed_q && cnt_q == LAST - 1'b1) begin
        commit  = ~smooth;
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= LAST;
    end else begin
      trig_q  <= trig;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  // R3: commit only while the trigger is steadily high
  p_commit_trig_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (trig && $past(trig)));
  // R6: no commit while smooth is still set
  p_commit_smooth_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !smooth);
  // R4: one rising trigger yields at most a single commit pulse
  p_commit_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

// File: rtl/pwm_stage_chan.sv
module pwm_stage_chan #(
  parameter int CW  = 16,
  parameter int PSW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit,
  input  logic [CW-1:0]  st_per,
  input  logic [CW-1:0]  st_duty,
  input  logic [PSW-1:0] st_ps,
  input  logic           st_pol,
  output logic           pwm
);
  logic [CW-1:0]  pend_per_q, pend_duty_q, act_per_q, act_duty_q, cnt_q, cnt_d;
  logic [PSW-1:0] pend_ps_q, act_ps_q, pcnt_q, pcnt_d;
  logic           pend_pol_q, act_pol_q, pend_v_q, pend_v_d, pwm_q, pwm_d;
  logic           en, tick, wrap, apply;

  assign en    = (act_per_q != '0);
  assign tick  = en && (pcnt_q == act_ps_q);
  assign wrap  = tick && (cnt_q == act_per_q - 1'b1);
  assign apply = pend_v_q && (wrap || !en);

  always_comb begin
    pend_v_d = commit ? 1'b1 : (apply ? 1'b0 : pend_v_q);
    pcnt_d   = '0;
    cnt_d    = '0;
    if (!apply && en) begin
      pcnt_d = tick ? '0 : pcnt_q + 1'b1;
      cnt_d  = cnt_q;
      if (tick) cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end
    pwm_d = (en && (cnt_q < act_duty_q)) ^ act_pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_per_q <= '0; pend_duty_q <= '0; pend_ps_q <= '0; pend_pol_q <= 1'b0;
      act_per_q  <= '0; act_duty_q  <= '0; act_ps_q  <= '0; act_pol_q  <= 1'b0;
      pend_v_q   <= 1'b0;
      pcnt_q     <= '0;
      cnt_q      <= '0;
      pwm_q      <= 1'b0;
    end else begin
      if (commit) begin
        pend_per_q  <= st_per;
        pend_duty_q <= st_duty;
        pend_ps_q   <= st_ps;
        pend_pol_q  <= st_pol;
      end
      if (apply) begin
        act_per_q  <= pend_per_q;
        act_duty_q <= pend_duty_q;
        act_ps_q   <= pend_ps_q;
        act_pol_q  <= pend_pol_q;
      end
      pend_v_q <= pend_v_d;
      pcnt_q   <= pcnt_d;
      cnt_q    <= cnt_d;
      pwm_q    <= pwm_d;
    end
  end

  assign pwm = pwm_q;

  // R2: running settings move only in an apply cycle
  p_act_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> ($stable(act_per_q) && $stable(act_duty_q) &&
                $stable(act_ps_q) && $stable(act_pol_q)));
  // R9: an idle channel rests at the inactive level
  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pwm_q == $past(act_pol_q)));
  // R7: the period counter stays inside the running period
  p_count_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q < act_per_q));
endmodule

// File: rtl/pwm_staged_top.sv
module pwm_staged_top
  import pwm_stage_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int DW       = 32,
  parameter int AW       = 4,
  parameter int CW       = 16,
  parameter int PSW      = 4,
  parameter int HOLD_CYC = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int CTW = CTRL_STRIDE * NCH;
  localparam int PRW = PSW * NCH;

  logic [1:0]             rs_q;
  logic                   rst_sync_n;
  logic [CTW-1:0]         ctrl_w;
  logic [PRW-1:0]         presc_w;
  logic [NCH-1:0][CW-1:0] per_w, duty_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  pwm_stage_regs #(.NCH(NCH), .DW(DW), .AW(AW), .CW(CW), .PSW(PSW)) regs_i (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .ctrl_o(ctrl_w), .presc_o(presc_w), .per_o(per_w), .duty_o(duty_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic commit_w;

    pwm_stage_gate #(.HOLD_CYC(HOLD_CYC)) gate_i (
      .clk(clk), .rst_n(rst_sync_n),
      .trig(ctrl_w[c*CTRL_STRIDE + TRIG_OFS]),
      .smooth(ctrl_w[c*CTRL_STRIDE + SMOOTH_OFS]),
      .commit(commit_w)
    );

    pwm_stage_chan #(.CW(CW), .PSW(PSW)) chan_i (
      .clk(clk), .rst_n(rst_sync_n), .commit(commit_w),
      .st_per(per_w[c]), .st_duty(duty_w[c]),
      .st_ps(presc_w[c*PSW +: PSW]),
      .st_pol(ctrl_w[c*CTRL_STRIDE + POL_OFS]),
      .pwm(pwm_out[c])
    );
  end
endmodule

// File: tb/pwm_staged_top_tb_top.sv
module pwm_staged_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4, DW = 32, AW = 4, CW = 16, PSW = 4, HOLD = 40;
  localparam int SETTLE = 200;

  typedef struct packed { int ch; int per; int duty; int ps; int pol; } vec_t;
  localparam vec_t VECS [6] = '{
    '{0, 10,  3, 0, 0},
    '{0,  8,  5, 2, 0},
    '{1, 12, 12, 1, 0},
    '{1,  6,  2, 0, 1},
    '{3, 16,  0, 3, 0},
    '{2,  5,  4, 4, 1}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [DW-1:0]  wdata = '0, rdata;
  logic [NCH-1:0] pwm_out;
  logic [DW-1:0]  ctrl_sh = '0;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_staged_top #(.NCH(NCH), .DW(DW), .AW(AW), .CW(CW), .PSW(PSW), .HOLD_CYC(HOLD))
    dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
           .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = AW'(a);
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // set trigger/smooth of channel c in the shadow and write it out
  task automatic set_ts(input int c, input bit t, input bit s);
    ctrl_sh[3*c]   = t;
    ctrl_sh[3*c+1] = s;
    wr(0, ctrl_sh);
  endtask

  task automatic prep(input int c);
    set_ts(c, 1'b0, 1'b1);
    idle(HOLD + 5);
  endtask

  task automatic stage(input int c, input int per, input int duty, input int ps, input int pol);
    logic [DW-1:0] p;
    wr(2 + 2*c, DW'(per));
    wr(3 + 2*c, DW'(duty));
    rd(1, p);
    p[c*PSW +: PSW] = PSW'(ps);
    wr(1, p);
    ctrl_sh[3*c+2] = pol[0];
    wr(0, ctrl_sh);
  endtask

  task automatic program_ch(input int c, input int per, input int duty, input int ps, input int pol);
    prep(c);
    stage(c, per, duty, ps, pol);
    set_ts(c, 1'b1, 1'b0);
    idle(HOLD + 5);
    idle(SETTLE);
  endtask

  function automatic int win_len(input int per, input int ps);
    return (per == 0) ? SETTLE : 2 * per * (ps + 1);
  endfunction

  // expected high cycles over win_len, from R7, R9 and R10
  function automatic int exp_high(input int per, input int duty, input int ps, input int pol);
    int act;
    act = (per == 0) ? 0 : 2 * ((duty < per) ? duty : per) * (ps + 1);
    return pol ? win_len(per, ps) - act : act;
  endfunction

  task automatic meas(input int c, input int per, input int ps, output int hi);
    hi = 0;
    for (int i = 0; i < win_len(per, ps); i++) begin
      @(posedge clk); #1;
      if (pwm_out[c]) hi++;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] d;
    int hi;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R11: reset state
    chk(int'(pwm_out), 0, "R11 outputs after reset");
    rd(0, d); chk(int'(d), 0, "R11 control after reset");
    rd(2, d); chk(int'(d), 0, "R11 period0 after reset");

    // table of vectors (R3, R7, R10)
    for (int v = 0; v < 6; v++) begin
      program_ch(VECS[v].ch, VECS[v].per, VECS[v].duty, VECS[v].ps, VECS[v].pol);
      meas(VECS[v].ch, VECS[v].per, VECS[v].ps, hi);
      chk(hi, exp_high(VECS[v].per, VECS[v].duty, VECS[v].ps, VECS[v].pol), "R7 R3 R10 table vector");
    end

    // R1: readback of staged registers of channel 2, unmapped address
    rd(6, d); chk(int'(d), 5, "R1 period ch2 readback");
    rd(7, d); chk(int'(d), 4, "R1 duty ch2 readback");
    rd(15, d); chk(int'(d), 0, "R1 unmapped reads zero");

    // R2: staging with smooth set leaves ch0 running 8/5/2
    prep(0);
    stage(0, 4, 1, 2, 0);
    idle(SETTLE);
    meas(0, 8, 2, hi); chk(hi, exp_high(8, 5, 2, 0), "R2 staged writes hold old output");

    // R4: short trigger pulse ignored
    set_ts(0, 1'b1, 1'b0); idle(HOLD / 2);
    set_ts(0, 1'b0, 1'b1); idle(SETTLE);
    meas(0, 8, 2, hi); chk(hi, exp_high(8, 5, 2, 0), "R4 short pulse no commit");

    // R5: re-rise too soon after a fall, then held long
    set_ts(0, 1'b1, 1'b0); idle(15);
    set_ts(0, 1'b0, 1'b1); idle(10);
    set_ts(0, 1'b1, 1'b0); idle(HOLD + 20);
    idle(SETTLE);
    meas(0, 8, 2, hi); chk(hi, exp_high(8, 5, 2, 0), "R5 early re-trigger ignored");

    // R3: proper handshake now commits the staged 4/1/2
    prep(0);
    set_ts(0, 1'b1, 1'b0); idle(HOLD + 5); idle(SETTLE);
    meas(0, 4, 2, hi); chk(hi, exp_high(4, 1, 2, 0), "R3 commit after full hold");

    // R6: trigger held with smooth still set
    prep(0);
    stage(0, 10, 10, 0, 0);
    set_ts(0, 1'b1, 1'b1); idle(HOLD + 20); idle(SETTLE);
    meas(0, 4, 2, hi); chk(hi, exp_high(4, 1, 2, 0), "R6 smooth set blocks commit");

    // R8: ch0 prescale change by read-modify-write leaves other channels
    program_ch(0, 10, 10, 0, 0);
    meas(0, 10, 0, hi); chk(hi, exp_high(10, 10, 0, 0), "R8 ch0 new waveform");
    meas(1, 6, 0, hi);  chk(hi, exp_high(6, 2, 0, 1), "R8 ch1 untouched");
    rd(1, d);
    chk(int'(d[2*PSW +: PSW]), 4, "R8 ch2 prescale field intact");
    chk(int'(d[3*PSW +: PSW]), 3, "R8 ch3 prescale field intact");

    // R9, R10: all-zero commit idles the channel at its inactive level
    program_ch(0, 0, 0, 0, 0);
    meas(0, 0, 0, hi); chk(hi, 0, "R9 idle normal stays low");
    program_ch(0, 0, 0, 0, 1);
    meas(0, 0, 0, hi); chk(hi, SETTLE, "R10 idle inverted stays high");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule